// File: doc/BRIEF.md
# Comparator-Driven Phase Alignment Sequencer

This block brings a tunable delay element into phase with a reference clock. It owns a 6-bit phase code that drives the delay element. It moves that code one step at a time and reads back a one-bit phase comparator after each step. Every step follows the same order: present the code, hold it for a settle time, then toggle a load strobe so the delay element takes it. Only after that is the comparator sampled. The comparator passes through a two-flop synchronizer, and the sample is taken a fixed number of cycles after the load toggle.

After a start pulse, the sequencer looks for a falling edge of the comparator. It then probes the edge five steps upward and three steps back down. It backs off five more steps and looks for the edge a second time. When the second search lands on the edge, it steps the code back by one, loads it and reports the number of sampled adjustments. A probe that fails sends the sequencer back to a fresh search, which starts from the code last written. The run ends in failure when the attempts or the adjustment budget run out.

Top module: `phase_align_seq`

## Requirements
- R1: After reset the phase code is 0, the load strobe is 0, done and fail are 0, and the adjustment count is 0.
- R2: A new code is presented at least SETTLE_CYC cycles before the load strobe toggles, and the code never changes in the cycle the strobe toggles. Each step changes the code by 0, +1 or -1 modulo 64, so code 0 minus one is 63.
- R3: Search steps follow one rule. The first search step of an attempt rewrites the current code. After each search sample the code goes down by one if the comparator read 0 and up by one if it read 1. The search ends on a falling transition, where the previous sample was 1 and the current sample is 0.
- R4: Forward probe: the code where the edge was found is rewritten and then raised, for five samples in all. If any of these samples reads 1, the attempt restarts from the last written code.
- R5: Backward probe: the code is lowered for three samples. If any of them reads 1, the attempt restarts.
- R6: Retreat: the code is lowered for five more samples. If the fifth sample still reads 0, the attempt restarts. Otherwise a second search starts under the rule of R3, with the last sample (1) as the previous value.
- R7: When the second search finds its falling transition, the code becomes the last written code minus one (mod 64) and is loaded. done pulses in the same cycle as that final load toggle. adj_count equals the number of sampled steps; the final load is not counted.
- R8: The sampled step that brings the adjustment count to 2^ADJ_W-1 ends the run with a fail pulse, and adj_count shows that value.
- R9: A run makes at most 10 attempts. A restart that would begin an eleventh attempt ends the run with a fail pulse instead.
- R10: done and fail each last one cycle and never occur together. adj_count and the code hold after the end of a run until the next start. A start pulse during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an alignment run (accepted only when idle) |
| cmp_in | input | 1 | Asynchronous phase comparator output |
| phase_code | output | CODE_W | Code presented to the delay element |
| load_tgl | output | 1 | Toggles once per step to load phase_code |
| done | output | 1 | One-cycle pulse on successful alignment |
| fail | output | 1 | One-cycle pulse when attempts or the adjustment budget run out |
| adj_count | output | ADJ_W | Sampled steps taken in the current or last run |

## Verification
A wrong stage or step counter shows up when the run ends. The final code or the adjustment count then differs from a model that follows the rules, and for a clean edge the mismatch appears within one run of about fifty steps. A wrong restart decision shows up as a run that succeeds when it should fail, or the reverse. Timing faults inside a step can be seen at once: a code change in the same cycle as the load toggle, or a jump of more than one code.

// File: rtl/phase_align_seq.sv
module phase_align_seq #(
  parameter int CODE_W        = 6,
  parameter int ADJ_W         = 16,
  parameter int SETTLE_CYC    = 2,
  parameter int SAMPLE_WAIT   = 4,
  parameter int FWD_STEPS     = 5,
  parameter int BACK_STEPS    = 3,
  parameter int RETREAT_STEPS = 5,
  parameter int MAX_TRIES     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cmp_in,
  output logic [CODE_W-1:0] phase_code,
  output logic              load_tgl,
  output logic              done,
  output logic              fail,
  output logic [ADJ_W-1:0]  adj_count
);
  localparam int TMAX  = (SETTLE_CYC > SAMPLE_WAIT) ? SETTLE_CYC : SAMPLE_WAIT;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int SMAX0 = (FWD_STEPS > BACK_STEPS) ? FWD_STEPS : BACK_STEPS;
  localparam int SMAX  = (SMAX0 > RETREAT_STEPS) ? SMAX0 : RETREAT_STEPS;
  localparam int CW    = $clog2(SMAX + 1);
  localparam int TRW   = $clog2(MAX_TRIES + 1);
  localparam logic [ADJ_W-1:0] ADJ_LAST = ~ADJ_W'(1);
  localparam logic [TRW-1:0]   TRY_LAST = TRW'(MAX_TRIES - 1);

  typedef enum logic [1:0] {IDLE, SETTLE, SAMPLE} st_t;
  typedef enum logic [2:0] {SRCH, FWD, BACK, RETR, RSRCH, FIN} stage_t;

  st_t             st;
  stage_t          stage, nstage;
  logic [1:0]      sync;
  logic            prev, restart, hit;
  logic [CW-1:0]   cnt, ncnt;
  logic [TRW-1:0]  tries;
  logic [TW-1:0]   tmr;
  logic [CODE_W-1:0] ncode;

  wire cmp_s = sync[1];
  wire [CODE_W-1:0] code_up = CODE_W'(phase_code + 1'b1);
  wire [CODE_W-1:0] code_dn = CODE_W'(phase_code - 1'b1);
  wire adj_hit  = (adj_count == ADJ_LAST);
  wire tries_out = restart && (tries == TRY_LAST);

  assign hit = (cmp_s != prev) && !cmp_s;

  always_comb begin
    nstage  = stage;
    ncode   = phase_code;
    ncnt    = CW'(cnt + 1'b1);
    restart = 1'b0;
    case (stage)
      SRCH, RSRCH: begin
        if (hit) begin
          nstage = (stage == SRCH) ? FWD : FIN;
          ncode  = (stage == SRCH) ? phase_code : code_dn;
          ncnt   = '0;
        end else begin
          ncode = cmp_s ? code_up : code_dn;
        end
      end
      FWD: begin
        if (cmp_s) restart = 1'b1;
        else if (cnt == CW'(FWD_STEPS - 1)) begin
          nstage = BACK; ncode = code_dn; ncnt = '0;
        end else ncode = code_up;
      end
      BACK: begin
        if (cmp_s) restart = 1'b1;
        else begin
          ncode = code_dn;
          if (cnt == CW'(BACK_STEPS - 1)) begin nstage = RETR; ncnt = '0; end
        end
      end
      RETR: begin
        if (cnt == CW'(RETREAT_STEPS - 1)) begin
          if (!cmp_s) restart = 1'b1;
          else begin nstage = RSRCH; ncnt = '0; end
        end else ncode = code_dn;
      end
      default: ;
    endcase
    if (restart) begin
      nstage = SRCH;
      ncode  = phase_code;
      ncnt   = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; stage <= SRCH; sync <= '0; prev <= 1'b0;
      cnt <= '0; tries <= '0; tmr <= '0;
      phase_code <= '0; load_tgl <= 1'b0;
      done <= 1'b0; fail <= 1'b0; adj_count <= '0;
    end else begin
      sync <= {sync[0], cmp_in};
      done <= 1'b0;
      fail <= 1'b0;
      case (st)
        IDLE: if (start) begin
          adj_count <= '0; tries <= '0; prev <= cmp_s;
          stage <= SRCH; cnt <= '0;
          tmr <= TW'(SETTLE_CYC - 1); st <= SETTLE;
        end
        SETTLE: begin
          if (tmr != '0) tmr <= tmr - 1'b1;
          else begin
            load_tgl <= ~load_tgl;
            if (stage == FIN) begin done <= 1'b1; st <= IDLE; end
            else begin tmr <= TW'(SAMPLE_WAIT - 1); st <= SAMPLE; end
          end
        end
        SAMPLE: begin
          if (tmr != '0) tmr <= tmr - 1'b1;
          else begin
            adj_count <= adj_count + 1'b1;
            if (adj_hit || tries_out) begin
              fail <= 1'b1; st <= IDLE;
            end else begin
              prev <= cmp_s; stage <= nstage; cnt <= ncnt;
              phase_code <= ncode;
              if (restart) tries <= tries + 1'b1;
              tmr <= TW'(SETTLE_CYC - 1); st <= SETTLE;
            end
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phase_align_seq_chk.sv
module phase_align_seq_chk #(
  parameter int CODE_W = 6,
  parameter int ADJ_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [CODE_W-1:0] phase_code,
  input logic              load_tgl,
  input logic              done,
  input logic              fail,
  input logic [ADJ_W-1:0]  adj_count
);
  p_step_unit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_code != $past(phase_code)) |->
      (phase_code == CODE_W'($past(phase_code) + 1'b1) ||
       phase_code == CODE_W'($past(phase_code) - 1'b1)));

  p_code_before_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_tgl != $past(load_tgl)) |-> $stable(phase_code));

  p_final_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (load_tgl != $past(load_tgl)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_fail_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> !fail);

  p_done_fail_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  p_adj_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_count != $past(adj_count) && adj_count != ADJ_W'($past(adj_count) + 1'b1))
      |-> $past(start));
endmodule

bind phase_align_seq phase_align_seq_chk #(.CODE_W(CODE_W), .ADJ_W(ADJ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .phase_code(phase_code),
  .load_tgl(load_tgl), .done(done), .fail(fail), .adj_count(adj_count)
);

// File: tb/tb_phase_align_seq.sv
module tb_phase_align_seq;
  localparam int SETTLE = 2;
  localparam int NV = 7;
  // {comparator map (bit i = comparator level at code i), glitched load index}
  localparam logic [71:0] VECS [0:NV-1] = '{
    {64'h0000_0000_FFFF_FFFF, 8'd0},   // clean edge
    {64'h0FFF_FF00_0000_0000, 8'd0},   // start low, wraps 0 -> 63
    {64'h0000_0004_FFFF_FFFF, 8'd0},   // false edge in forward probe
    {64'h0000_0000_FFFF_FFFF, 8'd40},  // noise in backward probe
    {64'h0000_0000_C000_0000, 8'd0},   // retreat never clears
    {64'h0000_0000_FFFF_FFFF, 8'd20},  // glitch during search
    {64'hF000_0000_0000_000F, 8'd0}    // high band across wrap
  };

  logic clk = 0, rst_n = 0, start = 0, start_c = 0;
  logic [63:0] mask = '0;
  int glitch = 0;
  int nchk = 0, nfail = 0;

  logic [5:0] code_a, code_c, loaded_a = '0, loaded_c = '0;
  logic load_a, load_c, done_a, done_c, fail_a, fail_c, cmp_a, cmp_c;
  logic [15:0] adj_a;
  logic [4:0]  adj_c;
  int lcnt_a = 0;

  always #4 clk = ~clk;

  always @(load_a) begin loaded_a = code_a; lcnt_a = lcnt_a + 1; end
  always @(load_c) loaded_c = code_c;
  assign cmp_a = mask[loaded_a] ^ (glitch != 0 && lcnt_a == glitch);
  assign cmp_c = mask[loaded_c];

  phase_align_seq #(.SETTLE_CYC(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_in(cmp_a),
    .phase_code(code_a), .load_tgl(load_a), .done(done_a), .fail(fail_a),
    .adj_count(adj_a));

  phase_align_seq #(.ADJ_W(5)) dut_c (
    .clk(clk), .rst_n(rst_n), .start(start_c), .cmp_in(cmp_c),
    .phase_code(code_c), .load_tgl(load_c), .done(done_c), .fail(fail_c),
    .adj_count(adj_c));

  // R2 monitor on the ports
  int early = 0, odd = 0, since = 0;
  bit saw_wrap = 0;
  logic [5:0] pc_prev = '0;
  logic ld_prev = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      since = (code_a != pc_prev) ? 0 : since + 1;
      if (code_a != pc_prev && code_a != 6'(pc_prev + 1) && code_a != 6'(pc_prev - 1)) odd++;
      if (pc_prev == 6'd0 && code_a == 6'd63) saw_wrap = 1;
      if (load_a != ld_prev && since < SETTLE) early++;
    end
    pc_prev = code_a;
    ld_prev = load_a;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL R7 watchdog: got 0 expected 1 (run completion)");
    summary();
    $finish;
  end

  // Independent model of the rules: returns {fail, adj[15:0], code[5:0]}
  function automatic logic [22:0] model_run(input logic [63:0] m, input int g, input int maxadj);
    int code, adj, tries, loads, stage, cnt;
    bit prev, c, rs;
    code = 0; adj = 0; tries = 0; loads = 0; stage = 0; cnt = 0;
    prev = m[0];
    for (int it = 0; it < 100000; it++) begin
      loads++;
      c = m[code] ^ (g != 0 && loads == g);
      adj++;
      if (adj == maxadj) return {1'b1, 16'(adj), 6'(code)};
      rs = 0;
      case (stage)
        0, 4: begin
          if (c != prev && !c) begin
            if (stage == 4) return {1'b0, 16'(adj), 6'((code + 63) % 64)};
            stage = 1; cnt = 0;
          end else code = c ? (code + 1) % 64 : (code + 63) % 64;
        end
        1: begin
          cnt++;
          if (c) rs = 1;
          else if (cnt == 5) begin stage = 2; cnt = 0; code = (code + 63) % 64; end
          else code = (code + 1) % 64;
        end
        2: begin
          cnt++;
          if (c) rs = 1;
          else begin
            code = (code + 63) % 64;
            if (cnt == 3) begin stage = 3; cnt = 0; end
          end
        end
        default: begin
          cnt++;
          if (cnt == 5) begin
            if (!c) rs = 1; else begin stage = 4; cnt = 0; end
          end else code = (code + 63) % 64;
        end
      endcase
      if (rs) begin
        tries++;
        if (tries == 10) return {1'b1, 16'(adj), 6'(code)};
        stage = 0; cnt = 0;
      end
      prev = c;
    end
    return '0;
  endfunction

  task automatic do_reset();
    @(negedge clk) rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    lcnt_a = 0;
  endtask

  task automatic run(input logic [63:0] m, input int g, input bit extra,
                     output bit ended, output bit f, output int adj, output int code);
    int n;
    mask = m; glitch = g;
    do_reset();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    n = 0;
    while (!(done_a || fail_a) && n < 60000) begin
      @(negedge clk);
      n++;
      start = (extra && n == 30);
    end
    start = 0;
    ended = done_a || fail_a;
    f = fail_a; adj = int'(adj_a); code = int'(code_a);
  endtask

  function automatic string tag(input int i);
    case (i)
      0: return "R7"; 1: return "R3"; 2: return "R4"; 3: return "R5";
      4: return "R9"; 5: return "R4"; default: return "R3";
    endcase
  endfunction

  initial begin
    bit ended, f;
    int adj, code;
    logic [22:0] e;

    // R1 reset state
    do_reset();
    @(negedge clk);
    chk(code_a == 0, "R1", "code after reset", code_a, 0);
    chk(load_a == 0, "R1", "load after reset", load_a, 0);
    chk(done_a == 0 && fail_a == 0, "R1", "done/fail after reset", {done_a, fail_a}, 0);
    chk(adj_a == 0, "R1", "adj after reset", adj_a, 0);

    for (int i = 0; i < NV; i++) begin
      e = model_run(VECS[i][71:8], int'(VECS[i][7:0]), 65535);
      run(VECS[i][71:8], int'(VECS[i][7:0]), 0, ended, f, adj, code);
      chk(ended, tag(i), $sformatf("vec %0d ended", i), ended, 1);
      chk(f == e[22], tag(i), $sformatf("vec %0d fail flag", i), f, e[22]);
      chk(adj == int'(e[21:6]), tag(i), $sformatf("vec %0d adj count", i), adj, e[21:6]);
      if (!e[22]) chk(code == int'(e[5:0]), tag(i), $sformatf("vec %0d final code", i), code, e[5:0]);
      if (i == 0) begin
        chk(adj == 51, "R7", "clean edge hand value adj", adj, 51);
        chk(code == 31, "R7", "clean edge hand value code", code, 31);
      end
      if (i == 4) chk(f, "R6", "retreat stuck low fails", f, 1);
      @(negedge clk);
      chk(!done_a && !fail_a, "R10", "end pulse one cycle", {done_a, fail_a}, 0);
      repeat (4) @(negedge clk);
      chk(int'(adj_a) == adj && int'(code_a) == code, "R10", "hold after end", adj_a, adj);
    end
    chk(saw_wrap, "R2", "code wrapped 0 to 63", saw_wrap, 1);

    // R10 start while busy is ignored
    e = model_run(VECS[0][71:8], 0, 65535);
    run(VECS[0][71:8], 0, 1, ended, f, adj, code);
    chk(adj == int'(e[21:6]) && !f, "R10", "busy start ignored adj", adj, e[21:6]);
    chk(code == int'(e[5:0]), "R10", "busy start ignored code", code, e[5:0]);

    // R8 adjustment budget, small instance (cap 31)
    begin
      int n;
      mask = VECS[0][71:8]; glitch = 0;
      do_reset();
      @(negedge clk) start_c = 1;
      @(negedge clk) start_c = 0;
      n = 0;
      while (!(done_c || fail_c) && n < 20000) begin @(negedge clk); n++; end
      e = model_run(VECS[0][71:8], 0, 31);
      chk(fail_c && !done_c, "R8", "cap reached fails", fail_c, 1);
      chk(int'(adj_c) == 31 && int'(e[21:6]) == 31, "R8", "adj at cap", adj_c, 31);
    end

    chk(early == 0, "R2", "loads before settle", early, 0);
    chk(odd == 0, "R2", "steps larger than one", odd, 0);

    summary();
    $finish;
  end
endmodule